// File: doc/BRIEF.md
# Host Block-Protocol Retransmission Controller

This block sits on the hosting side of a half-duplex, block-oriented link layer. It decides which block goes out next, and it fills in the protocol control byte (PCB) of that block. It does not handle payload bytes, CRC generation or bus timing. Each request goes to a frame transmitter, which reports completion on `tx_done`. A frame receiver supplies the PCB and CRC verdict of each incoming block. A separate waiting-time timer is restarted by the controller and reports expiry back to it.

The controller opens the link with a soft-reset supervisory request. After that it carries one command and its response at a time. It keeps the send sequence bit and the expected receive sequence bit, and it acknowledges each chunk of an incoming chained response. It answers every wait-time extension request. Link errors are recovered with a bounded number of acknowledge blocks or retransmissions. When that budget runs out it escalates to a soft reset. If the soft reset also fails to get through, it raises a sticky fatal flag and stops.

Top module: `t1h_host_link`

## Requirements
- R1: While `rst` is high, `tx_req`, `app_ready`, `rsp_valid` and `link_fatal` are 0. After release, the first block requested is the soft-reset request, PCB 0xCF. `app_ready` stays 0 until the soft-reset response, PCB 0xEF, arrives error-free.
- R2: Information-block PCB layout:
  - bit 7 is 0, bit 6 is the send sequence bit and bit 5 is the more-data flag; bits 4..0 are 0.
  - The send sequence bit is 0 after a soft reset or resync.
  - It toggles each time the peer acknowledges one of our information blocks. The peer acknowledges either with its own information block or with a clean positive acknowledge.
- R3: An error-free incoming information block whose sequence bit (PCB bit 6) equals the expected receive bit produces a one-cycle `rsp_valid` pulse. `rsp_more` carries its bit 5, and the expected receive bit toggles.
- R4: When such a block has bit 5 set, the controller requests a positive acknowledge: PCB = 0x80 | (next expected receive bit << 4), with error code 00.
- R5: Suppose the last block sent was an information block with the more-data flag set. An error-free acknowledge block (PCB bits 7..5 = 100, code 00) whose bit 4 differs from that block's sequence bit advances the send sequence bit. The controller then returns to ready without delivering a response.
- R6: Recovery blocks while awaiting a response:
  - Bad CRC: acknowledge with code 01 (PCB 0x81 | expected receive bit << 4).
  - Timeout, wrong-sequence information block or unexpected supervisory block: code 10.
  - An acknowledge block that does not advance the exchange: the last block is resent. `tx_resend` is 1 when that block is an information block.
- R7: At most 10 consecutive recovery blocks are sent. The next error sends the soft-reset request 0xCF. Any error-free block that advances the exchange clears the count.
- R8: While awaiting the soft-reset response, any other outcome resends 0xCF, at most 10 times. The next failure sets `link_fatal`. It stays set until reset, and no further block is requested.
- R9: A wait-time extension request (PCB 0xC3), received error-free, is always answered with PCB 0xE3 and does not change the retry count. `bwt_restart` pulses in the cycle after every `tx_done`.
- R10: `app_resync` while ready sends the resync request (PCB 0xC0). Its error-free response (PCB 0xE0) sets both sequence bits to 0.
- R11: Inputs outside their window have no effect:
  - `rx_valid` and `bwt_expired` are ignored while ready.
  - `app_send_valid` is ignored while `app_ready` is 0.
- R12: `tx_req` is a one-cycle pulse. No new request is issued until `tx_done` is seen and a receive event or timeout has been processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| app_send_valid | input | 1 | Application offers the next command chunk |
| app_send_more | input | 1 | Offered chunk is followed by more chunks |
| app_resync | input | 1 | Request sequence resynchronisation |
| app_ready | output | 1 | Controller idle and able to accept a chunk or resync |
| rsp_valid | output | 1 | One-cycle pulse: a response chunk was accepted |
| rsp_more | output | 1 | Accepted response chunk has more chunks following |
| tx_req | output | 1 | One-cycle request to the frame transmitter |
| tx_pcb | output | 8 | PCB of the requested block |
| tx_resend | output | 1 | Requested block reuses the previous command payload |
| tx_done | input | 1 | Transmitter finished the requested block |
| rx_valid | input | 1 | Receiver decoded a block |
| rx_crc_ok | input | 1 | The decoded block passed its CRC check |
| rx_pcb | input | 8 | PCB of the decoded block |
| bwt_expired | input | 1 | Block waiting time elapsed without a block |
| bwt_restart | output | 1 | Restart the waiting-time timer |
| link_fatal | output | 1 | Sticky: link could not be recovered |

## Verification
The bench targets the edges of the retry budget:
- Five errors are followed by a good block and then ten more errors. A counter that is never cleared would escalate too early; an off-by-one would send an eleventh acknowledge or escalate on the tenth.
- Soft-reset retries are driven to exhaustion. A design that never stops would keep requesting blocks after the fatal point.

Sequence handling is checked across chained responses, chained commands, resync and wait-time extension. A design that toggled the send bit on its own acknowledge blocks, or after a wait-time answer, would emit the wrong bit 6 on the next command. Receive events arriving while idle are injected to catch a controller that reacts outside its waiting window.

// File: rtl/t1h_pkg.sv
package t1h_pkg;

  localparam logic [7:0] PCB_SRST_REQ  = 8'hCF;
  localparam logic [7:0] PCB_SRST_RSP  = 8'hEF;
  localparam logic [7:0] PCB_RSYNC_REQ = 8'hC0;
  localparam logic [7:0] PCB_RSYNC_RSP = 8'hE0;
  localparam logic [7:0] PCB_WTX_REQ   = 8'hC3;
  localparam logic [7:0] PCB_WTX_RSP   = 8'hE3;

  localparam logic [1:0] ACK_OK    = 2'b00;
  localparam logic [1:0] ACK_CRC   = 2'b01;
  localparam logic [1:0] ACK_OTHER = 2'b10;

  typedef enum logic [1:0] {BK_INFO, BK_ACK, BK_SUP, BK_BAD} blk_kind_e;

  typedef struct packed {
    blk_kind_e  kind;
    logic       seq;
    logic       more;
    logic [1:0] code;
  } pcb_fields_t;

  typedef enum logic [2:0] {ST_BOOT, ST_IDLE, ST_TXW, ST_RXW, ST_FATAL} link_state_e;
  typedef enum logic [1:0] {PH_NORMAL, PH_SRST, PH_RSYNC} link_phase_e;

  function automatic logic [7:0] mk_info(input logic ns, input logic more);
    return {1'b0, ns, more, 5'b00000};
  endfunction

  function automatic logic [7:0] mk_ack(input logic nr, input logic [1:0] code);
    return {3'b100, nr, 2'b00, code};
  endfunction

endpackage

// File: rtl/t1h_pcb_decode.sv
module t1h_pcb_decode
  import t1h_pkg::*;
(
  input  logic [7:0]  pcb,
  output pcb_fields_t fld
);
  always_comb begin
    fld.kind = BK_BAD;
    fld.seq  = 1'b0;
    fld.more = 1'b0;
    fld.code = pcb[1:0];
    if (!pcb[7]) begin
      if (pcb[4:0] == 5'd0) fld.kind = BK_INFO;
      fld.seq  = pcb[6];
      fld.more = pcb[5];
    end else if (!pcb[6]) begin
      if (!pcb[5] && pcb[3:2] == 2'b00 && pcb[1:0] != 2'b11) fld.kind = BK_ACK;
      fld.seq = pcb[4];
    end else begin
      fld.kind = BK_SUP;
    end
  end
endmodule

// File: rtl/t1h_retry_budget.sv
module t1h_retry_budget #(
  parameter int MAX_RETRY = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bump,
  output logic exhausted
);
  localparam int CW = $clog2(MAX_RETRY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_RETRY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (bump && cnt != LIMIT) cnt <= cnt + CW'(1);
  end

  assign exhausted = (cnt == LIMIT);

  a_r7_within_budget: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  a_r7_one_step: assert property (@(posedge clk) disable iff (rst)
    (bump && !clr && !exhausted) |=> cnt == $past(cnt) + CW'(1));

  a_r7_cleared: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
endmodule

// File: rtl/t1h_seq_track.sv
module t1h_seq_track (
  input  logic clk,
  input  logic rst,
  input  logic zero,
  input  logic adv_send,
  input  logic adv_recv,
  output logic ns,
  output logic nr
);
  always_ff @(posedge clk) begin
    if (rst || zero) begin
      ns <= 1'b0;
      nr <= 1'b0;
    end else begin
      if (adv_send) ns <= ~ns;
      if (adv_recv) nr <= ~nr;
    end
  end

  a_r10_zeroed: assert property (@(posedge clk) disable iff (rst)
    zero |=> (!ns && !nr));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!zero && !adv_send) |=> ns == $past(ns));
endmodule

// File: rtl/t1h_host_link.sv
module t1h_host_link
  import t1h_pkg::*;
#(
  parameter int MAX_RETRY = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       app_send_valid,
  input  logic       app_send_more,
  input  logic       app_resync,
  output logic       app_ready,
  output logic       rsp_valid,
  output logic       rsp_more,
  output logic       tx_req,
  output logic [7:0] tx_pcb,
  output logic       tx_resend,
  input  logic       tx_done,
  input  logic       rx_valid,
  input  logic       rx_crc_ok,
  input  logic [7:0] rx_pcb,
  input  logic       bwt_expired,
  output logic       bwt_restart,
  output logic       link_fatal
);
  link_state_e state, state_d;
  link_phase_e phase, phase_d;
  pcb_fields_t fld;

  logic       ns, nr, exhausted;
  logic [7:0] last_pcb;
  logic       i_unacked, i_unacked_d, i_more, i_more_d;

  logic       do_tx, orig, resend_d, deliver, more_d;
  logic [7:0] pcb_d;
  logic       bump, clr, seq_zero, adv_send, adv_recv, fatal_d;
  logic       err, err_last, fin_s;
  logic [1:0] err_code;

  t1h_pcb_decode u_dec (.pcb(rx_pcb), .fld(fld));

  t1h_retry_budget #(.MAX_RETRY(MAX_RETRY)) u_budget (
    .clk(clk), .rst(rst), .clr(clr), .bump(bump), .exhausted(exhausted)
  );

  t1h_seq_track u_seq (
    .clk(clk), .rst(rst), .zero(seq_zero), .adv_send(adv_send),
    .adv_recv(adv_recv), .ns(ns), .nr(nr)
  );

  always_comb begin
    state_d     = state;
    phase_d     = phase;
    do_tx       = 1'b0;
    orig        = 1'b0;
    pcb_d       = 8'h00;
    resend_d    = 1'b0;
    deliver     = 1'b0;
    more_d      = 1'b0;
    bump        = 1'b0;
    clr         = 1'b0;
    seq_zero    = 1'b0;
    adv_send    = 1'b0;
    adv_recv    = 1'b0;
    i_unacked_d = i_unacked;
    i_more_d    = i_more;
    fatal_d     = link_fatal;
    err         = 1'b0;
    err_last    = 1'b0;
    err_code    = ACK_OTHER;
    fin_s       = 1'b0;

    unique case (state)
      ST_BOOT: begin
        do_tx   = 1'b1;
        orig    = 1'b1;
        pcb_d   = PCB_SRST_REQ;
        phase_d = PH_SRST;
        clr     = 1'b1;
        state_d = ST_TXW;
      end
      ST_IDLE: begin
        if (app_resync) begin
          do_tx   = 1'b1;
          orig    = 1'b1;
          pcb_d   = PCB_RSYNC_REQ;
          phase_d = PH_RSYNC;
          state_d = ST_TXW;
        end else if (app_send_valid) begin
          do_tx       = 1'b1;
          orig        = 1'b1;
          pcb_d       = mk_info(ns, app_send_more);
          i_unacked_d = 1'b1;
          i_more_d    = app_send_more;
          phase_d     = PH_NORMAL;
          state_d     = ST_TXW;
        end
      end
      ST_TXW: begin
        if (tx_done) state_d = ST_RXW;
      end
      ST_RXW: begin
        if (rx_valid || bwt_expired) begin
          if (rx_valid && !rx_crc_ok) begin
            err      = 1'b1;
            err_code = ACK_CRC;
          end else if (rx_valid && rx_pcb == PCB_WTX_REQ) begin
            do_tx   = 1'b1;
            orig    = 1'b1;
            pcb_d   = PCB_WTX_RSP;
            state_d = ST_TXW;
          end else if (!rx_valid) begin
            err = 1'b1;
          end else if (phase == PH_SRST) begin
            if (rx_pcb == PCB_SRST_RSP) fin_s = 1'b1;
            else err = 1'b1;
          end else if (phase == PH_RSYNC) begin
            if (rx_pcb == PCB_RSYNC_RSP) fin_s = 1'b1;
            else err = 1'b1;
          end else if (fld.kind == BK_INFO && fld.seq == nr) begin
            deliver  = 1'b1;
            more_d   = fld.more;
            adv_recv = 1'b1;
            clr      = 1'b1;
            if (i_unacked) begin
              adv_send    = 1'b1;
              i_unacked_d = 1'b0;
            end
            if (fld.more) begin
              do_tx   = 1'b1;
              orig    = 1'b1;
              pcb_d   = mk_ack(~nr, ACK_OK);
              state_d = ST_TXW;
            end else begin
              state_d = ST_IDLE;
            end
          end else if (fld.kind == BK_ACK) begin
            if (i_unacked && i_more && fld.seq != ns && fld.code == ACK_OK) begin
              clr         = 1'b1;
              adv_send    = 1'b1;
              i_unacked_d = 1'b0;
              state_d     = ST_IDLE;
            end else begin
              err      = 1'b1;
              err_last = 1'b1;
            end
          end else begin
            err = 1'b1;
          end

          if (fin_s) begin
            seq_zero    = 1'b1;
            clr         = 1'b1;
            i_unacked_d = 1'b0;
            phase_d     = PH_NORMAL;
            state_d     = ST_IDLE;
          end

          if (err) begin
            if (exhausted) begin
              if (phase == PH_SRST) begin
                fatal_d = 1'b1;
                state_d = ST_FATAL;
              end else begin
                do_tx       = 1'b1;
                orig        = 1'b1;
                pcb_d       = PCB_SRST_REQ;
                phase_d     = PH_SRST;
                clr         = 1'b1;
                i_unacked_d = 1'b0;
                state_d     = ST_TXW;
              end
            end else begin
              bump    = 1'b1;
              do_tx   = 1'b1;
              state_d = ST_TXW;
              if (phase == PH_SRST) pcb_d = PCB_SRST_REQ;
              else if (phase == PH_RSYNC) pcb_d = PCB_RSYNC_REQ;
              else if (err_last) begin
                pcb_d    = last_pcb;
                resend_d = ~last_pcb[7];
              end else pcb_d = mk_ack(nr, err_code);
            end
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_BOOT;
      phase       <= PH_SRST;
      tx_req      <= 1'b0;
      tx_pcb      <= 8'h00;
      tx_resend   <= 1'b0;
      last_pcb    <= 8'h00;
      i_unacked   <= 1'b0;
      i_more      <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_more    <= 1'b0;
      bwt_restart <= 1'b0;
      app_ready   <= 1'b0;
      link_fatal  <= 1'b0;
    end else begin
      state       <= state_d;
      phase       <= phase_d;
      tx_req      <= do_tx;
      if (do_tx) begin
        tx_pcb    <= pcb_d;
        tx_resend <= resend_d;
      end
      if (orig) last_pcb <= pcb_d;
      i_unacked   <= i_unacked_d;
      i_more      <= i_more_d;
      rsp_valid   <= deliver;
      rsp_more    <= deliver & more_d;
      bwt_restart <= (state == ST_TXW) && tx_done;
      app_ready   <= (state_d == ST_IDLE);
      link_fatal  <= fatal_d;
    end
  end

  a_r1_boot_first: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BOOT) |=> (tx_req && tx_pcb == PCB_SRST_REQ));

  a_r12_tx_pulse: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> !tx_req);

  a_r12_no_tx_waiting: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TXW && !tx_done) |=> !tx_req);

  a_r2_info_reserved: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_pcb[7]) |-> tx_pcb[4:0] == 5'd0);

  a_r4_chain_ack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RXW && phase == PH_NORMAL && rx_valid && rx_crc_ok &&
     rx_pcb[7] == 1'b0 && rx_pcb[5] && rx_pcb[4:0] == 5'd0 && rx_pcb[6] == nr)
    |=> (tx_req && tx_pcb[7:5] == 3'b100 && tx_pcb[1:0] == ACK_OK && rsp_valid));

  a_r9_wtx_answer: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RXW && rx_valid && rx_crc_ok && rx_pcb == PCB_WTX_REQ)
    |=> (tx_req && tx_pcb == PCB_WTX_RSP));

  a_r9_timer_restart: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TXW && tx_done) |=> bwt_restart);

  a_r8_fatal_sticky: assert property (@(posedge clk) disable iff (rst)
    link_fatal |=> (link_fatal && !tx_req && !app_ready));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !app_send_valid && !app_resync) |=> !tx_req);
endmodule

// File: tb/t1h_host_link_tb_top.sv
module t1h_host_link_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       app_send_valid = 1'b0, app_send_more = 1'b0, app_resync = 1'b0;
  logic       tx_done = 1'b0, rx_valid = 1'b0, rx_crc_ok = 1'b0, bwt_expired = 1'b0;
  logic [7:0] rx_pcb = 8'h00;
  logic       app_ready, rsp_valid, rsp_more, tx_req, tx_resend, bwt_restart, link_fatal;
  logic [7:0] tx_pcb;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit bns = 1'b0;
  bit bnr = 1'b0;

  always #4 clk = ~clk;

  t1h_host_link dut_i (
    .clk(clk), .rst(rst), .app_send_valid(app_send_valid), .app_send_more(app_send_more),
    .app_resync(app_resync), .app_ready(app_ready), .rsp_valid(rsp_valid), .rsp_more(rsp_more),
    .tx_req(tx_req), .tx_pcb(tx_pcb), .tx_resend(tx_resend), .tx_done(tx_done),
    .rx_valid(rx_valid), .rx_crc_ok(rx_crc_ok), .rx_pcb(rx_pcb), .bwt_expired(bwt_expired),
    .bwt_restart(bwt_restart), .link_fatal(link_fatal)
  );

  function automatic logic [7:0] f_info(bit s, bit m);
    return {1'b0, s, m, 5'b0};
  endfunction

  function automatic logic [7:0] f_ack(bit r, logic [1:0] c);
    return {3'b100, r, 2'b00, c};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_tx(logic [7:0] exp, bit exp_rs, string tag);
    for (int n = 0; n < 40 && !tx_req; n++) @(negedge clk);
    check(tx_req && tx_pcb == exp && tx_resend == exp_rs, tag,
          {22'd0, tx_req, tx_resend, tx_pcb}, {22'd0, 1'b1, exp_rs, exp});
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    check(bwt_restart == 1'b1, "R9 timer restart", {31'd0, bwt_restart}, 32'd1);
  endtask

  task automatic feed(bit ok, logic [7:0] p);
    rx_valid = 1'b1; rx_crc_ok = ok; rx_pcb = p;
    @(negedge clk);
    rx_valid = 1'b0; rx_crc_ok = 1'b0;
  endtask

  task automatic tmo();
    bwt_expired = 1'b1;
    @(negedge clk);
    bwt_expired = 1'b0;
  endtask

  task automatic send_app(bit m);
    for (int n = 0; n < 40 && !app_ready; n++) @(negedge clk);
    app_send_valid = 1'b1; app_send_more = m;
    @(negedge clk);
    app_send_valid = 1'b0; app_send_more = 1'b0;
  endtask

  task automatic rsp_check(logic [7:0] p, bit m, string tag);
    feed(1'b1, p);
    check(rsp_valid && rsp_more == m, tag, {30'd0, rsp_valid, rsp_more}, {30'd0, 1'b1, m});
  endtask

  // one random recovery-worthy event while awaiting a response in normal phase
  task automatic inject_err(output logic [7:0] exp);
    int sel = int'($urandom % 3);
    if (sel == 0) begin
      feed(1'b0, 8'($urandom));
      exp = f_ack(bnr, 2'b01);
    end else if (sel == 1) begin
      tmo();
      exp = f_ack(bnr, 2'b10);
    end else begin
      feed(1'b1, f_info(~bnr, 1'b0));
      exp = f_ack(bnr, 2'b10);
    end
  endtask

  task automatic inject_any();
    if ($urandom % 2 == 0) feed(1'b0, 8'($urandom));
    else tmo();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [7:0] e;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(!tx_req && !app_ready && !rsp_valid && !link_fatal, "R1 reset outputs",
          {28'd0, tx_req, app_ready, rsp_valid, link_fatal}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    expect_tx(8'hCF, 1'b0, "R1 first block soft reset");
    check(!app_ready, "R1 not ready before response", {31'd0, app_ready}, 32'd0);
    feed(1'b1, 8'hEF);
    check(app_ready, "R1 ready after response", {31'd0, app_ready}, 32'd1);

    // simple exchange
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R2 first info seq 0");
    rsp_check(f_info(bnr, 0), 1'b0, "R3 response delivered");
    bns = ~bns; bnr = ~bnr;

    // chained response
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R2 seq toggled");
    rsp_check(f_info(bnr, 1), 1'b1, "R3 more-data response");
    bns = ~bns; bnr = ~bnr;
    expect_tx(f_ack(bnr, 2'b00), 1'b0, "R4 chain ack");
    rsp_check(f_info(bnr, 0), 1'b0, "R3 last chunk");
    bnr = ~bnr;

    // chained command
    send_app(1'b1);
    expect_tx(f_info(bns, 1), 1'b0, "R2 more flag");
    feed(1'b1, f_ack(~bns, 2'b00));
    check(app_ready && !rsp_valid, "R5 chain ack ready", {30'd0, app_ready, rsp_valid}, 32'd2);
    bns = ~bns;
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R5 next chunk seq");
    rsp_check(f_info(bnr, 0), 1'b0, "R3 after chain");
    bns = ~bns; bnr = ~bnr;

    // recovery kinds
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R2 before errors");
    feed(1'b0, 8'h55);
    expect_tx(f_ack(bnr, 2'b01), 1'b0, "R6 crc error ack");
    feed(1'b1, f_ack(bns, 2'b00));
    expect_tx(f_info(bns, 0), 1'b1, "R6 resend last");
    tmo();
    expect_tx(f_ack(bnr, 2'b10), 1'b0, "R6 timeout ack");
    rsp_check(f_info(bnr, 0), 1'b0, "R6 recovered");
    bns = ~bns; bnr = ~bnr;

    // wait-time extension
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R2 before wtx");
    feed(1'b1, 8'hC3);
    expect_tx(8'hE3, 1'b0, "R9 wtx answered");
    rsp_check(f_info(bnr, 0), 1'b0, "R9 response after wtx");
    bns = ~bns; bnr = ~bnr;

    // ignored inputs while ready
    feed(1'b1, 8'hC3);
    tmo();
    repeat (3) @(negedge clk);
    check(!tx_req && app_ready, "R11 idle ignores rx", {30'd0, tx_req, app_ready}, 32'd1);
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R11 state unchanged");

    // budget clears on progress
    for (int k = 0; k < 5; k++) begin
      inject_err(e);
      expect_tx(e, 1'b0, "R6 random recovery");
    end
    rsp_check(f_info(bnr, 0), 1'b0, "R7 progress clears");
    bns = ~bns; bnr = ~bnr;
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R2 before budget");
    for (int k = 0; k < 10; k++) begin
      inject_err(e);
      expect_tx(e, 1'b0, "R7 within budget");
    end
    inject_any();
    expect_tx(8'hCF, 1'b0, "R7 escalate to soft reset");
    feed(1'b1, 8'hEF);
    bns = 1'b0; bnr = 1'b0;
    check(app_ready, "R7 ready after soft reset", {31'd0, app_ready}, 32'd1);

    // resync
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R2 after soft reset");
    rsp_check(f_info(bnr, 0), 1'b0, "R3 after soft reset");
    bns = 1'b1; bnr = 1'b1;
    app_resync = 1'b1;
    @(negedge clk);
    app_resync = 1'b0;
    expect_tx(8'hC0, 1'b0, "R10 resync request");
    feed(1'b0, 8'hE0);
    expect_tx(8'hC0, 1'b0, "R10 resync retried");
    feed(1'b1, 8'hE0);
    bns = 1'b0; bnr = 1'b0;
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R10 seq zeroed");
    rsp_check(f_info(bnr, 0), 1'b0, "R10 receive zeroed");
    bns = 1'b1; bnr = 1'b1;

    // fatal path
    send_app(1'b0);
    expect_tx(f_info(bns, 0), 1'b0, "R2 before fatal");
    for (int k = 0; k < 10; k++) begin
      inject_err(e);
      expect_tx(e, 1'b0, "R7 budget again");
    end
    inject_any();
    expect_tx(8'hCF, 1'b0, "R7 escalate again");
    for (int k = 0; k < 10; k++) begin
      inject_any();
      expect_tx(8'hCF, 1'b0, "R8 soft reset retried");
    end
    inject_any();
    repeat (4) @(negedge clk);
    check(link_fatal && !tx_req, "R8 fatal raised", {30'd0, link_fatal, tx_req}, 32'd2);
    app_send_valid = 1'b1;
    repeat (3) @(negedge clk);
    app_send_valid = 1'b0;
    check(link_fatal && !tx_req && !app_ready, "R11 send ignored when fatal",
          {29'd0, link_fatal, tx_req, app_ready}, 32'd4);

    done = 1'b1;
    report();
  end
endmodule